// File: doc/BRIEF.md
# VPW Pulse-Width Symbol Decoder

This block watches a single variable-pulse-width bus line and turns the time between its level changes into protocol symbols. The line passes through a synchronizer. An optional inversion lets the block work with a transceiver that presents the bus level either directly or inverted. After that, the block measures each interval in timing units, where one clock cycle counts as one unit. Each finished interval is classified by its length and by the level it represented. The result appears as a one-cycle strobe with a symbol code and a level flag.

Pulses too short to be real are filtered out, and the interval counter keeps running straight through them. An interval that passes the filter but is still too short for a data bit is reported as an invalid bit, and timing restarts from that pulse's edges. Passive periods have no closing edge when the bus goes quiet. For these, the end-of-data, end-of-frame, separation and idle symbols are reported as the counter passes each threshold in turn. An over-long active period is likewise reported as a break once it passes its threshold.

Top module: `vpw_symbol_decoder`

## Requirements
- R1: After reset, with the line held passive, `sym_valid_o` stays low and `sym_code_o` and `sym_level_o` read 0.
- R2: With `invert_i` high, a low line is taken as active and a high line as passive. Decoded symbols are identical to the non-inverted case for the same bus waveform.
- R3: A level lasting 7 units or fewer is discarded. The interval that was running continues to count through it, so the surrounding time forms one interval. A level of 8 units is accepted.
- R4: An accepted interval of 8 to 34 units is reported as invalid bit (code 9) with its own level, and the next interval is timed from its closing edge.
- R5: Data zero (code 0) is reported for passive 35–96 or active 97–163 units. Data one (code 1) is reported for passive 97–163 or active 35–96 units.
- R6: An active interval of 164–239 units is reported as start of frame (code 2).
- R7: A passive period reaching 164 units is reported as end of data (code 3) when it reaches 164 units. The next active interval of 35–163 units is then reported as a normalization bit (code 7) in place of a data bit.
- R8: A passive period is reported as end of frame (code 4) when it reaches 240 units, as separation (code 5) when it reaches 281, and as idle (code 6) when it reaches 301. The edge that ends such a period reports nothing further.
- R9: An active period is reported as break (code 8) when it reaches 240 units. Its closing edge reports nothing.
- R10: `sym_valid_o` is high for exactly one cycle per symbol. `sym_level_o` gives the level of the reported interval: 1 for active, 0 for passive.
- R11: The interval counter saturates at its maximum, so a passive period of any length produces no symbols beyond those of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw bus receive line |
| invert_i | input | 1 | 1: line is inverted relative to the bus level |
| sym_valid_o | output | 1 | One-cycle strobe for a decoded symbol |
| sym_code_o | output | 4 | Symbol code (0 zero, 1 one, 2 SOF, 3 EOD, 4 EOF, 5 separation, 6 idle, 7 normalization, 8 break, 9 invalid) |
| sym_level_o | output | 1 | Level of the interval the symbol came from |

## Verification
The bench builds the decoder with its default parameters: a two-stage synchronizer, a 10-bit counter, a filter limit of 7, and thresholds 34/96/163/239/280/300. With those values, every range edge (8, 34, 35, 96, 97, 163, 164, 240, 281, 301) can be reached with short pulse sequences, and a 1100-unit quiet period drives the counter past its saturation point. A glitch exactly at the filter limit and a polarity switch mid-run cover the input conditioning path.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

   typedef enum logic [3:0] {
      SYM_ZERO = 4'd0,
      SYM_ONE  = 4'd1,
      SYM_SOF  = 4'd2,
      SYM_EOD  = 4'd3,
      SYM_EOF  = 4'd4,
      SYM_IFS  = 4'd5,
      SYM_IDLE = 4'd6,
      SYM_NB   = 4'd7,
      SYM_BRK  = 4'd8,
      SYM_INV  = 4'd9
   } vpw_sym_e;

   localparam logic [3:0] SYM_LAST = 4'd9;

endpackage

// File: rtl/vpw_line_cond.sv
module vpw_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic invert_i,
   output logic level_o
);

   logic raw_s;

   generate
      if (SYNC_STAGES < 1) begin : g_bad
         $error("vpw_line_cond: SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= line_i;
         end
         assign raw_s = q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[SYNC_STAGES-2:0], line_i};
         end
         assign raw_s = q[SYNC_STAGES-1];
      end
   endgenerate

   // 1 = active bus level after polarity correction
   assign level_o = raw_s ^ invert_i;

endmodule

// File: rtl/vpw_edge_filter.sv
module vpw_edge_filter #(
   parameter int CNT_W = 10,
   parameter int FILT  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level_i,
   output logic             accept_o,
   output logic             steady_o,
   output logic             lvl_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_next_o,
   output logic [CNT_W-1:0] interval_o
);

   localparam int              PC_W    = $clog2(FILT + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] FILT_C  = CNT_W'(FILT);
   localparam logic [PC_W-1:0]  PC_LAST = PC_W'(FILT - 1);

   generate
      if (FILT < 2) begin : g_bad_filt
         $error("vpw_edge_filter: FILT must be at least 2");
      end
      if (FILT >= (1 << CNT_W)) begin : g_bad_width
         $error("vpw_edge_filter: counter too narrow for filter");
      end
   endgenerate

   logic             lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PC_W-1:0]  pc_q;
   logic             differ;

   always_comb begin
      differ     = level_i ^ lvl_q;
      accept_o   = differ && (pc_q == PC_LAST);
      steady_o   = !differ;
      cnt_next_o = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      // the new level began FILT samples before acceptance
      interval_o = cnt_next_o - FILT_C;
      lvl_o      = lvl_q;
      cnt_o      = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         cnt_q <= CNT_MAX;
         pc_q  <= '0;
      end else if (accept_o) begin
         lvl_q <= level_i;
         cnt_q <= FILT_C;
         pc_q  <= '0;
      end else begin
         cnt_q <= cnt_next_o;
         pc_q  <= differ ? pc_q + 1'b1 : '0;
      end
   end

endmodule

// File: rtl/vpw_symbol_class.sv
module vpw_symbol_class
   import vpw_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int INV_MAX = 34,
   parameter int TV1_MAX = 96,
   parameter int TV2_MAX = 163,
   parameter int TV3_MAX = 239,
   parameter int EOF_MAX = 280,
   parameter int IFS_MAX = 300
) (
   input  logic [CNT_W-1:0] interval_i,
   input  logic             level_i,
   input  logic             nb_arm_i,
   output vpw_sym_e         code_o
);

   always_comb begin
      if (interval_i <= CNT_W'(INV_MAX)) begin
         code_o = SYM_INV;
      end else if (level_i) begin
         if (interval_i <= CNT_W'(TV1_MAX))      code_o = nb_arm_i ? SYM_NB : SYM_ONE;
         else if (interval_i <= CNT_W'(TV2_MAX)) code_o = nb_arm_i ? SYM_NB : SYM_ZERO;
         else if (interval_i <= CNT_W'(TV3_MAX)) code_o = SYM_SOF;
         else                                    code_o = SYM_BRK;
      end else begin
         if (interval_i <= CNT_W'(TV1_MAX))      code_o = SYM_ZERO;
         else if (interval_i <= CNT_W'(TV2_MAX)) code_o = SYM_ONE;
         else if (interval_i <= CNT_W'(TV3_MAX)) code_o = SYM_EOD;
         else if (interval_i <= CNT_W'(EOF_MAX)) code_o = SYM_EOF;
         else if (interval_i <= CNT_W'(IFS_MAX)) code_o = SYM_IFS;
         else                                    code_o = SYM_IDLE;
      end
   end

endmodule

// File: rtl/vpw_symbol_decoder.sv
module vpw_symbol_decoder
   import vpw_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2,
   parameter int IGNORE_MAX  = 7,
   parameter int INV_MAX     = 34,
   parameter int TV1_MAX     = 96,
   parameter int TV2_MAX     = 163,
   parameter int TV3_MAX     = 239,
   parameter int EOF_MAX     = 280,
   parameter int IFS_MAX     = 300
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_i,
   input  logic       invert_i,
   output logic       sym_valid_o,
   output logic [3:0] sym_code_o,
   output logic       sym_level_o
);

   localparam int FILT       = IGNORE_MAX + 1;
   localparam int PASS_STEPS = 4;
   localparam int STG_W      = 3;
   localparam logic [STG_W-1:0] STG_DONE = STG_W'(PASS_STEPS);

   generate
      if (!(IGNORE_MAX < INV_MAX && INV_MAX < TV1_MAX && TV1_MAX < TV2_MAX &&
            TV2_MAX < TV3_MAX && TV3_MAX < EOF_MAX && EOF_MAX < IFS_MAX)) begin : g_bad_order
         $error("vpw_symbol_decoder: thresholds must be strictly increasing");
      end
      if (IFS_MAX + 1 >= (1 << CNT_W)) begin : g_bad_width
         $error("vpw_symbol_decoder: CNT_W too small for IFS_MAX");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] pass_thr(input logic [STG_W-1:0] s);
      case (s)
         3'd0:    pass_thr = CNT_W'(TV2_MAX);
         3'd1:    pass_thr = CNT_W'(TV3_MAX);
         3'd2:    pass_thr = CNT_W'(EOF_MAX);
         3'd3:    pass_thr = CNT_W'(IFS_MAX);
         default: pass_thr = {CNT_W{1'b1}};
      endcase
   endfunction

   function automatic vpw_sym_e pass_sym(input logic [STG_W-1:0] s);
      case (s)
         3'd0:    pass_sym = SYM_EOD;
         3'd1:    pass_sym = SYM_EOF;
         3'd2:    pass_sym = SYM_IFS;
         default: pass_sym = SYM_IDLE;
      endcase
   endfunction

   logic             bus_lvl;
   logic             edge_accept;
   logic             steady;
   logic             cur_lvl;
   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] interval;
   vpw_sym_e         edge_code;

   vpw_line_cond #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_i),
      .invert_i (invert_i),
      .level_o  (bus_lvl)
   );

   vpw_edge_filter #(
      .CNT_W (CNT_W),
      .FILT  (FILT)
   ) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (bus_lvl),
      .accept_o   (edge_accept),
      .steady_o   (steady),
      .lvl_o      (cur_lvl),
      .cnt_o      (run_cnt),
      .cnt_next_o (cnt_next),
      .interval_o (interval)
   );

   logic [STG_W-1:0] stage_q;
   logic             nb_arm_q;

   vpw_symbol_class #(
      .CNT_W   (CNT_W),
      .INV_MAX (INV_MAX),
      .TV1_MAX (TV1_MAX),
      .TV2_MAX (TV2_MAX),
      .TV3_MAX (TV3_MAX),
      .EOF_MAX (EOF_MAX),
      .IFS_MAX (IFS_MAX)
   ) u_class (
      .interval_i (interval),
      .level_i    (cur_lvl),
      .nb_arm_i   (nb_arm_q),
      .code_o     (edge_code)
   );

   logic             done;
   logic [CNT_W-1:0] tmo_thr;
   vpw_sym_e         tmo_code;
   logic             tmo_hit;
   logic             edge_emit;
   logic             emit;
   vpw_sym_e         emit_code;

   always_comb begin
      if (cur_lvl) begin
         done     = (stage_q != '0);
         tmo_thr  = CNT_W'(TV3_MAX);
         tmo_code = SYM_BRK;
      end else begin
         done     = (stage_q >= STG_DONE);
         tmo_thr  = pass_thr(stage_q);
         tmo_code = pass_sym(stage_q);
      end
      tmo_hit   = steady && !done && (cnt_next > tmo_thr);
      // an interval already closed by a timeout reports nothing at its edge
      edge_emit = edge_accept && (stage_q == '0);
      emit      = edge_emit || tmo_hit;
      emit_code = edge_emit ? edge_code : tmo_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q     <= STG_DONE;
         nb_arm_q    <= 1'b0;
         sym_valid_o <= 1'b0;
         sym_code_o  <= 4'd0;
         sym_level_o <= 1'b0;
      end else begin
         if (edge_accept)  stage_q <= '0;
         else if (tmo_hit) stage_q <= stage_q + 1'b1;
         if (emit) begin
            nb_arm_q    <= (emit_code == SYM_EOD);
            sym_code_o  <= emit_code;
            sym_level_o <= cur_lvl;
         end
         sym_valid_o <= emit;
      end
   end

endmodule

// File: rtl/vpw_symbol_decoder_chk.sv
module vpw_symbol_decoder_chk
   import vpw_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sym_valid,
   input logic [3:0]       sym_code,
   input logic             sym_level,
   input logic             accept,
   input logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid |=> !sym_valid);

   p_active_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && (sym_code == SYM_SOF || sym_code == SYM_BRK || sym_code == SYM_NB))
      |-> sym_level);

   p_passive_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && (sym_code == SYM_EOD || sym_code == SYM_EOF ||
                     sym_code == SYM_IFS || sym_code == SYM_IDLE))
      |-> !sym_level);

   p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid |-> (sym_code <= SYM_LAST));

   p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> (cnt >= $past(cnt)));

   p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !accept) |=> (cnt == CNT_MAX));

endmodule

bind vpw_symbol_decoder vpw_symbol_decoder_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sym_valid (sym_valid_o),
   .sym_code  (sym_code_o),
   .sym_level (sym_level_o),
   .accept    (edge_accept),
   .cnt       (run_cnt)
);

// File: tb/vpw_symbol_decoder_tb_top.sv
`timescale 1ns/1ps
module vpw_symbol_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_i = 1'b0;
   logic       invert_i = 1'b0;
   logic       sym_valid_o;
   logic [3:0] sym_code_o;
   logic       sym_level_o;

   always #5 clk = ~clk;

   vpw_symbol_decoder dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line_i),
      .invert_i    (invert_i),
      .sym_valid_o (sym_valid_o),
      .sym_code_o  (sym_code_o),
      .sym_level_o (sym_level_o)
   );

   // stimulus: {bus level, duration}; 1 = active
   localparam int N_SEG = 22;
   localparam logic [11:0] SEG [N_SEG] = '{
      {1'b1, 11'd200}, {1'b0, 11'd64},  {1'b1, 11'd64},  {1'b0, 11'd128},
      {1'b1, 11'd128}, {1'b0, 11'd35},  {1'b1, 11'd96},  {1'b0, 11'd97},
      {1'b1, 11'd163}, {1'b0, 11'd20},  {1'b1, 11'd64},  {1'b0, 11'd200},
      {1'b1, 11'd64},  {1'b0, 11'd64},  {1'b1, 11'd164}, {1'b0, 11'd350},
      {1'b1, 11'd300}, {1'b0, 11'd350}, {1'b1, 11'd34},  {1'b0, 11'd8},
      {1'b1, 11'd64},  {1'b0, 11'd400}
   };
   // expected symbols: {code, level}
   localparam int N_EV = 31;
   localparam logic [4:0] EV [N_EV] = '{
      {4'd2, 1'b1}, {4'd0, 1'b0}, {4'd1, 1'b1}, {4'd1, 1'b0}, {4'd0, 1'b1},
      {4'd0, 1'b0}, {4'd1, 1'b1}, {4'd1, 1'b0}, {4'd0, 1'b1}, {4'd9, 1'b0},
      {4'd1, 1'b1}, {4'd3, 1'b0}, {4'd7, 1'b1}, {4'd0, 1'b0}, {4'd2, 1'b1},
      {4'd3, 1'b0}, {4'd4, 1'b0}, {4'd5, 1'b0}, {4'd6, 1'b0}, {4'd8, 1'b1},
      {4'd3, 1'b0}, {4'd4, 1'b0}, {4'd5, 1'b0}, {4'd6, 1'b0}, {4'd9, 1'b1},
      {4'd9, 1'b0}, {4'd1, 1'b1}, {4'd3, 1'b0}, {4'd4, 1'b0}, {4'd5, 1'b0},
      {4'd6, 1'b0}
   };

   int n_checks = 0;
   int n_fail   = 0;

   logic [3:0] ev_code [64];
   logic       ev_lvl  [64];
   int         ev_n = 0;
   logic [3:0] ex_code [64];
   logic       ex_lvl  [64];
   int         ex_n = 0;
   int         run_len = 0;
   int         max_run = 0;

   always @(negedge clk) begin
      if (rst_n && sym_valid_o) begin
         if (ev_n < 64) begin
            ev_code[ev_n] = sym_code_o;
            ev_lvl[ev_n]  = sym_level_o;
         end
         ev_n++;
         run_len++;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'd0, 4'd1: req_of = "R5";
         4'd2:       req_of = "R6";
         4'd3, 4'd7: req_of = "R7";
         4'd8:       req_of = "R9";
         4'd9:       req_of = "R4";
         default:    req_of = "R8";
      endcase
   endfunction

   task automatic expect_sym(input logic [3:0] c, input logic l);
      ex_code[ex_n] = c;
      ex_lvl[ex_n]  = l;
      ex_n++;
   endtask

   task automatic verify(input string req);
      check(ev_n == ex_n, req, "symbol count", ev_n, ex_n);
      for (int i = 0; i < ex_n && i < ev_n; i++) begin
         check(ev_code[i] == ex_code[i], req_of(ex_code[i]), $sformatf("code of symbol %0d", i),
               int'(ev_code[i]), int'(ex_code[i]));
         check(ev_lvl[i] == ex_lvl[i], "R10", $sformatf("level of symbol %0d", i),
               int'(ev_lvl[i]), int'(ex_lvl[i]));
      end
      ev_n = 0;
      ex_n = 0;
   endtask

   task automatic hold(input logic bus, input int n);
      line_i = bus ^ invert_i;
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: quiet after reset
      check(sym_valid_o == 1'b0, "R1", "valid after reset", int'(sym_valid_o), 0);
      check(sym_code_o == 4'd0, "R1", "code after reset", int'(sym_code_o), 0);
      check(sym_level_o == 1'b0, "R1", "level after reset", int'(sym_level_o), 0);
      hold(1'b0, 400);
      check(ev_n == 0, "R1", "symbols on idle line", ev_n, 0);
      ev_n = 0;

      // table of pulse sequences covering R4 R5 R6 R7 R8 R9
      for (int i = 0; i < N_SEG; i++) hold(SEG[i][11], int'(SEG[i][10:0]));
      for (int i = 0; i < N_EV; i++) expect_sym(EV[i][4:1], EV[i][0]);
      verify("R4 R5 R6 R7 R8 R9");

      // R3: 7-unit glitch inside an active interval is swallowed
      hold(1'b1, 30);
      hold(1'b0, 7);
      hold(1'b1, 30);
      hold(1'b0, 400);
      expect_sym(4'd1, 1'b1);
      expect_sym(4'd3, 1'b0);
      expect_sym(4'd4, 1'b0);
      expect_sym(4'd5, 1'b0);
      expect_sym(4'd6, 1'b0);
      verify("R3");

      // R11: very long quiet period, no extra symbols, then normal decoding
      hold(1'b1, 64);
      hold(1'b0, 1100);
      hold(1'b1, 64);
      hold(1'b0, 400);
      for (int k = 0; k < 2; k++) begin
         expect_sym(4'd1, 1'b1);
         expect_sym(4'd3, 1'b0);
         expect_sym(4'd4, 1'b0);
         expect_sym(4'd5, 1'b0);
         expect_sym(4'd6, 1'b0);
      end
      verify("R11");

      // R2: inverted line polarity
      invert_i = 1'b1;
      hold(1'b0, 50);
      hold(1'b1, 200);
      hold(1'b0, 64);
      hold(1'b1, 128);
      hold(1'b0, 400);
      check(line_i == 1'b1, "R2", "raw line idles high when inverted", int'(line_i), 1);
      expect_sym(4'd2, 1'b1);
      expect_sym(4'd0, 1'b0);
      expect_sym(4'd0, 1'b1);
      expect_sym(4'd3, 1'b0);
      expect_sym(4'd4, 1'b0);
      expect_sym(4'd5, 1'b0);
      expect_sym(4'd6, 1'b0);
      verify("R2");

      // R10: every strobe lasted one cycle
      check(max_run == 1, "R10", "longest strobe run", max_run, 1);
      summary();
   end

endmodule